// File: doc/BRIEF.md
# Clause-22 Management Register Slave

This block is the management-side slave of a small repeater device. It listens on the management data line, clocked by the management clock, and recognises clause-22 frames addressed to it. A frame begins with a run of ones, followed by the start pair 01, a two-bit opcode, a five-bit PHY address, a five-bit register address and a two-bit turnaround, and ends with sixteen data bits. Only frames carrying the fixed PHY address 5'h1F are answered. On a read the block takes over the line through a tri-state enable and shifts out sixteen bits. On a write it updates its single control register.

The control register holds the partition and jabber disables for the 10M and 100M repeater cores, plus a select for the 100M consecutive-collision limit. These fields are brought out as decoded outputs. Two status registers are read-only views of input pins. The sequencer has nine states. PREAMBLE counts ones and goes to START on a 0 once at least 32 ones have been seen. START goes to OPCODE on a 1 and back to PREAMBLE on a 0. OPCODE goes to PHYADDR on read or write and back to PREAMBLE otherwise. PHYADDR goes to REGADDR after five bits. REGADDR goes to TURN_RD or TURN_WR on an address match and back to PREAMBLE otherwise. TURN_RD goes to READ_DATA and TURN_WR goes to WRITE_DATA, each after two bits. READ_DATA and WRITE_DATA return to PREAMBLE after sixteen bits. All state changes happen on the rising edge of the management clock.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, mdio_oe is 0, all four disable outputs are 0 and coll_limit is 64.
- R2: A write frame to address 5'h1F, register 0, with opcode 01 updates the control fields at the clock edge that samples the last data bit. Bit 1 disables partition in the 10M core and bit 2 in the 100M core. Bit 3 disables jabber in the 10M core and bit 4 in the 100M core. The control outputs do not change while a read is being answered.
- R3: Register 0 bits 0 and 5 to 8, and bits 10 to 15, read as 0 whatever is written, so writing 16'hFFFF reads back 16'h021E.
- R4: A read frame (opcode 10) to register 1 returns stat_1 and to register 2 returns stat_2, MSB first. The value is taken at the edge that samples the second turnaround bit.
- R5: Register addresses 3 to 31 read as 16'h0000, and writes to them leave register 0 unchanged.
- R6: A frame whose PHY address is not 5'h1F never asserts mdio_oe and never changes register 0.
- R7: A frame preceded by fewer than 32 consecutive ones is ignored, and exactly 32 ones are enough.
- R8: On a read, mdio_oe stays 0 for the first turnaround bit and is 1 with mdio_out 0 for the second.
- R9: coll_limit is 64 when register 0 bit 9 is 0 and 128 when it is 1.
- R10: A frame with opcode 00 or 11 is ignored: no drive and no register change.
- R11: Each read drives the line for exactly 17 bit periods (second turnaround bit plus 16 data bits), after which mdio_oe returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdio_in | input | 1 | Management data line as seen at the pad |
| stat_1 | input | 16 | Contents returned for register 1 |
| stat_2 | input | 16 | Contents returned for register 2 |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Tri-state enable for the data line |
| no_part_10 | output | 1 | Disable partition in the 10M core (reg 0 bit 1) |
| no_part_100 | output | 1 | Disable partition in the 100M core (reg 0 bit 2) |
| no_jab_10 | output | 1 | Disable jabber in the 10M core (reg 0 bit 3) |
| no_jab_100 | output | 1 | Disable jabber in the 100M core (reg 0 bit 4) |
| coll_limit | output | 8 | 100M consecutive-collision limit, 64 or 128 (reg 0 bit 9) |

## Verification
The checker assumes that the master releases the line, which is pulled high, for a read's turnaround and data, so that no frame-like pattern appears while the slave is driving. It also assumes that reset is not asserted in the middle of an answered read, since its window counter measures whole reads. The bench drives the data line only at falling clock edges and holds the line high whenever the slave owns it. Before the short-preamble case it inserts idle zeros so that trailing ones from an earlier frame cannot add to the count. The status pins are changed only between frames.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [3:0] {
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYADDR,
        ST_REGADDR,
        ST_TURN_RD,
        ST_TURN_WR,
        ST_READ_DATA,
        ST_WRITE_DATA
    } mdio_state_e;

    // opcode pair as received, first bit in [1]
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    // control register field positions (decoded by the repeater cores)
    localparam int BIT_NOPART10  = 1;
    localparam int BIT_NOPART100 = 2;
    localparam int BIT_NOJAB10   = 3;
    localparam int BIT_NOJAB100  = 4;
    localparam int BIT_CLIMSEL   = 9;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          AW       = 5,
    parameter int          PRE_MIN  = 32,
    parameter logic [4:0]  PHY_ADDR = 5'h1F
) (
    input  logic          mdc,
    input  logic          rst_n,
    input  logic          mdio_in,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] reg_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          mdio_out,
    output logic          mdio_oe
);

    localparam int CW = $clog2(DW);
    localparam int PW = $clog2(PRE_MIN + 1);
    localparam logic [CW-1:0] CNT_ADR_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] CNT_DAT_LAST = CW'(DW - 1);
    localparam logic [CW-1:0] CNT_TA_LAST  = CW'(1);
    localparam logic [PW-1:0] PRE_FULL     = PW'(PRE_MIN);

    mdio_state_e   state, nxt;
    logic [CW-1:0] bit_cnt;
    logic [PW-1:0] pre_cnt;
    logic          op_first;
    logic          is_read;
    logic [AW-1:0] phy_sh;
    logic [AW-1:0] reg_sh;
    logic [DW-1:0] sh;
    logic          pre_full;
    logic          op_ok;

    assign pre_full = (pre_cnt == PRE_FULL);
    assign op_ok    = ({op_first, mdio_in} == OPC_READ) ||
                      ({op_first, mdio_in} == OPC_WRITE);

    // state register
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) state <= ST_PREAMBLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PREAMBLE:   if (!mdio_in && pre_full) nxt = ST_START;
            ST_START:      nxt = mdio_in ? ST_OPCODE : ST_PREAMBLE;
            ST_OPCODE:     if (bit_cnt == CNT_TA_LAST)
                               nxt = op_ok ? ST_PHYADDR : ST_PREAMBLE;
            ST_PHYADDR:    if (bit_cnt == CNT_ADR_LAST) nxt = ST_REGADDR;
            ST_REGADDR:    if (bit_cnt == CNT_ADR_LAST) begin
                               if (phy_sh != PHY_ADDR) nxt = ST_PREAMBLE;
                               else if (is_read)       nxt = ST_TURN_RD;
                               else                    nxt = ST_TURN_WR;
                           end
            ST_TURN_RD:    if (bit_cnt == CNT_TA_LAST) nxt = ST_READ_DATA;
            ST_TURN_WR:    if (bit_cnt == CNT_TA_LAST) nxt = ST_WRITE_DATA;
            ST_READ_DATA:  if (bit_cnt == CNT_DAT_LAST) nxt = ST_PREAMBLE;
            ST_WRITE_DATA: if (bit_cnt == CNT_DAT_LAST) nxt = ST_PREAMBLE;
            default:       nxt = ST_PREAMBLE;
        endcase
    end

    // counters and shift registers
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            pre_cnt  <= '0;
            op_first <= 1'b0;
            is_read  <= 1'b0;
            phy_sh   <= '0;
            reg_sh   <= '0;
            sh       <= '0;
        end else begin
            bit_cnt <= (nxt != state) ? '0 : bit_cnt + 1'b1;

            if (state == ST_PREAMBLE && mdio_in) begin
                if (!pre_full) pre_cnt <= pre_cnt + 1'b1;
            end else begin
                pre_cnt <= '0;
            end

            unique case (state)
                ST_OPCODE: begin
                    if (bit_cnt == '0) op_first <= mdio_in;
                    else               is_read  <= op_first;
                end
                ST_PHYADDR:    phy_sh <= {phy_sh[AW-2:0], mdio_in};
                ST_REGADDR:    reg_sh <= {reg_sh[AW-2:0], mdio_in};
                ST_TURN_RD:    if (bit_cnt == CNT_TA_LAST) sh <= rd_data;
                ST_READ_DATA:  sh <= {sh[DW-2:0], 1'b0};
                ST_WRITE_DATA: sh <= {sh[DW-2:0], mdio_in};
                default:       ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mdio_oe  = 1'b0;
        mdio_out = 1'b0;
        unique case (state)
            ST_TURN_RD:   mdio_oe = (bit_cnt == CNT_TA_LAST);
            ST_READ_DATA: begin
                mdio_oe  = 1'b1;
                mdio_out = sh[DW-1];
            end
            default:      ;
        endcase
    end

    assign reg_addr = reg_sh;
    assign wr_en    = (state == ST_WRITE_DATA) && (bit_cnt == CNT_DAT_LAST);
    assign wr_data  = {sh[DW-2:0], mdio_in};

endmodule

// File: rtl/mdio_ctrl_regs.sv
module mdio_ctrl_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 5,
    parameter int LIM_W  = 8,
    parameter int LIM_LO = 64,
    parameter int LIM_HI = 128
) (
    input  logic             mdc,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    stat_1,
    input  logic [DW-1:0]    stat_2,
    output logic [DW-1:0]    rd_data,
    output logic             no_part_10,
    output logic             no_part_100,
    output logic             no_jab_10,
    output logic             no_jab_100,
    output logic [LIM_W-1:0] coll_limit
);

    localparam logic [DW-1:0] WMASK = (DW'(1) << BIT_NOPART10)  |
                                      (DW'(1) << BIT_NOPART100) |
                                      (DW'(1) << BIT_NOJAB10)   |
                                      (DW'(1) << BIT_NOJAB100)  |
                                      (DW'(1) << BIT_CLIMSEL);

    logic [DW-1:0] ctrl;
    logic          sel_ctrl;

    assign sel_ctrl = wr_en && (reg_addr == AW'(0));

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (WMASK[i]) begin : g_flop
            always_ff @(posedge mdc or negedge rst_n) begin
                if (!rst_n)        ctrl[i] <= 1'b0;
                else if (sel_ctrl) ctrl[i] <= wr_data[i];
            end
        end else begin : g_zero
            assign ctrl[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            AW'(0):  rd_data = ctrl;
            AW'(1):  rd_data = stat_1;
            AW'(2):  rd_data = stat_2;
            default: rd_data = '0;
        endcase
    end

    assign no_part_10  = ctrl[BIT_NOPART10];
    assign no_part_100 = ctrl[BIT_NOPART100];
    assign no_jab_10   = ctrl[BIT_NOJAB10];
    assign no_jab_100  = ctrl[BIT_NOJAB100];
    assign coll_limit  = ctrl[BIT_CLIMSEL] ? LIM_W'(LIM_HI) : LIM_W'(LIM_LO);

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
    parameter int          DW       = 16,
    parameter int          AW       = 5,
    parameter int          PRE_MIN  = 32,
    parameter logic [4:0]  PHY_ADDR = 5'h1F,
    parameter int          LIM_W    = 8,
    parameter int          LIM_LO   = 64,
    parameter int          LIM_HI   = 128
) (
    input  logic             mdc,
    input  logic             rst_n,
    input  logic             mdio_in,
    input  logic [DW-1:0]    stat_1,
    input  logic [DW-1:0]    stat_2,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             no_part_10,
    output logic             no_part_100,
    output logic             no_jab_10,
    output logic             no_jab_100,
    output logic [LIM_W-1:0] coll_limit
);

    logic [AW-1:0] reg_addr;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;

    mdio_frame_fsm #(
        .DW(DW), .AW(AW), .PRE_MIN(PRE_MIN), .PHY_ADDR(PHY_ADDR)
    ) fsm_i (
        .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .rd_data(rd_data),
        .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    mdio_ctrl_regs #(
        .DW(DW), .AW(AW), .LIM_W(LIM_W), .LIM_LO(LIM_LO), .LIM_HI(LIM_HI)
    ) regs_i (
        .mdc(mdc), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .reg_addr(reg_addr), .stat_1(stat_1), .stat_2(stat_2),
        .rd_data(rd_data), .no_part_10(no_part_10), .no_part_100(no_part_100),
        .no_jab_10(no_jab_10), .no_jab_100(no_jab_100), .coll_limit(coll_limit)
    );

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
    parameter int DW     = 16,
    parameter int LIM_W  = 8,
    parameter int LIM_LO = 64,
    parameter int LIM_HI = 128
) (
    input logic             mdc,
    input logic             rst_n,
    input logic             mdio_out,
    input logic             mdio_oe,
    input logic             no_part_10,
    input logic             no_part_100,
    input logic             no_jab_10,
    input logic             no_jab_100,
    input logic [LIM_W-1:0] coll_limit
);

    localparam int RW = $clog2(DW + 3);
    localparam logic [RW-1:0] RUN_LEN = RW'(DW + 1);

    logic [RW-1:0] drive_run;
    logic [LIM_W+3:0] ctl_bus;

    assign ctl_bus = {coll_limit, no_jab_100, no_jab_10, no_part_100, no_part_10};

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n)       drive_run <= '0;
        else if (mdio_oe) drive_run <= drive_run + 1'b1;
        else              drive_run <= '0;
    end

    // R8: the first driven period is the turnaround zero
    a_r8_turn_zero: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R11: drive never lasts longer than one read
    a_r11_drive_bound: assert property (@(posedge mdc) disable iff (!rst_n)
        drive_run <= RUN_LEN);

    // R11: every drive window is a whole read
    a_r11_drive_whole: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> (drive_run == RUN_LEN));

    // R2: control outputs hold while a read is answered
    a_r2_ctrl_hold_read: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |=> $stable(ctl_bus));

    // R9: limit is always one of the two legal values
    a_r9_limit_legal: assert property (@(posedge mdc) disable iff (!rst_n)
        (coll_limit == LIM_W'(LIM_LO)) || (coll_limit == LIM_W'(LIM_HI)));

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
    .DW(DW), .LIM_W(LIM_W), .LIM_LO(LIM_LO), .LIM_HI(LIM_HI)
) chk_i (
    .mdc(mdc), .rst_n(rst_n), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .no_part_10(no_part_10), .no_part_100(no_part_100),
    .no_jab_10(no_jab_10), .no_jab_100(no_jab_100), .coll_limit(coll_limit)
);

// File: tb/mdio_mgmt_slave_tb_top.sv
module mdio_mgmt_slave_tb_top;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_in = 1'b1;
    logic [15:0] stat_1 = 16'h0000;
    logic [15:0] stat_2 = 16'h0000;
    logic        mdio_out, mdio_oe;
    logic        no_part_10, no_part_100, no_jab_10, no_jab_100;
    logic [7:0]  coll_limit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] m_ctrl = 16'h0000;   // reference model of register 0

    always #10 mdc = ~mdc;            // 50 MHz

    mdio_mgmt_slave dut_i (
        .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in),
        .stat_1(stat_1), .stat_2(stat_2),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .no_part_10(no_part_10), .no_part_100(no_part_100),
        .no_jab_10(no_jab_10), .no_jab_100(no_jab_100),
        .coll_limit(coll_limit)
    );

    always @(posedge mdc) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_ctrl(string req);
        int act, exp;
        act = {coll_limit, no_jab_100, no_jab_10, no_part_100, no_part_10};
        exp = {(m_ctrl[9] ? 8'd128 : 8'd64), m_ctrl[4], m_ctrl[3], m_ctrl[2], m_ctrl[1]};
        check(act == exp, req, "controls", act, exp);
    endtask

    function automatic logic [15:0] model_read(logic [4:0] ra);
        case (ra)
            5'd0:    return m_ctrl;
            5'd1:    return stat_1;
            5'd2:    return stat_2;
            default: return 16'h0000;
        endcase
    endfunction

    // one bit period: drive at falling edge, check after the rising edge
    task automatic send_bit(bit b, bit eo, bit eout, string req);
        mdio_in = b;
        @(posedge mdc);
        @(negedge mdc);
        check(mdio_oe == eo, req, "mdio_oe", int'(mdio_oe), int'(eo));
        if (eo) check(mdio_out == eout, req, "mdio_out", int'(mdio_out), int'(eout));
        check_ctrl(req);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0, 1'b0, "R11");
    endtask

    task automatic frame(int pre, logic [1:0] op, logic [4:0] phy,
                         logic [4:0] ra, logic [15:0] wd, string req);
        bit q[$];
        bit valid, rd, wr;
        logic [15:0] rdv;
        int hdr;
        for (int i = 0; i < pre; i++) q.push_back(1'b1);
        q.push_back(1'b0); q.push_back(1'b1);
        q.push_back(op[1]); q.push_back(op[0]);
        for (int i = 4; i >= 0; i--) q.push_back(phy[i]);
        for (int i = 4; i >= 0; i--) q.push_back(ra[i]);
        if (op == 2'b01) begin
            q.push_back(1'b1); q.push_back(1'b0);
            for (int i = 15; i >= 0; i--) q.push_back(wd[i]);
        end else begin
            for (int i = 0; i < 18; i++) q.push_back(1'b1);
        end
        valid = (pre >= 32) && (phy == 5'h1F);
        rd    = valid && (op == 2'b10);
        wr    = valid && (op == 2'b01);
        rdv   = model_read(ra);
        hdr   = pre + 14;
        for (int i = 0; i < q.size(); i++) begin
            bit eo, eout;
            string r;
            eo = 1'b0; eout = 1'b0; r = req;
            if (rd && i == hdr) begin
                eo = 1'b1; r = "R8";
            end else if (rd && i > hdr && i <= hdr + 16) begin
                eo = 1'b1; eout = rdv[15 - (i - hdr - 1)];
            end else if (rd && i == hdr + 17) begin
                r = "R11";
            end
            if (wr && ra == 5'd0 && i == q.size() - 1) m_ctrl = wd & 16'h021E;
            send_bit(q[i], eo, eout, r);
        end
        mdio_in = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge mdc);
        check(mdio_oe == 1'b0, "R1", "mdio_oe in reset", int'(mdio_oe), 0);
        check_ctrl("R1");
        check(coll_limit == 8'd64, "R1", "coll_limit in reset", int'(coll_limit), 64);
        rst_n = 1'b1;
        @(negedge mdc);
        check_ctrl("R1");

        // status reads
        stat_1 = 16'hA5C3; stat_2 = 16'h3C96;
        frame(32, 2'b10, 5'h1F, 5'd1, 16'h0, "R4");
        frame(32, 2'b10, 5'h1F, 5'd2, 16'h0, "R4");
        stat_1 = 16'h8001;
        frame(40, 2'b10, 5'h1F, 5'd1, 16'h0, "R4");

        // control writes and read-back
        frame(32, 2'b01, 5'h1F, 5'd0, 16'h0006, "R2");
        frame(32, 2'b10, 5'h1F, 5'd0, 16'h0, "R2");
        frame(32, 2'b01, 5'h1F, 5'd0, 16'h0018, "R2");
        frame(32, 2'b01, 5'h1F, 5'd0, 16'h0200, "R9");
        check(coll_limit == 8'd128, "R9", "coll_limit sel=1", int'(coll_limit), 128);
        frame(32, 2'b01, 5'h1F, 5'd0, 16'h0000, "R9");
        check(coll_limit == 8'd64, "R9", "coll_limit sel=0", int'(coll_limit), 64);

        // reserved bits
        frame(32, 2'b01, 5'h1F, 5'd0, 16'hFFFF, "R3");
        frame(32, 2'b10, 5'h1F, 5'd0, 16'h0, "R3");
        check(m_ctrl == 16'h021E, "R3", "model read-back", int'(m_ctrl), 'h21E);

        // unimplemented addresses
        frame(32, 2'b10, 5'h1F, 5'd3, 16'h0, "R5");
        frame(32, 2'b10, 5'h1F, 5'd31, 16'h0, "R5");
        frame(32, 2'b01, 5'h1F, 5'd5, 16'h0000, "R5");
        frame(32, 2'b10, 5'h1F, 5'd0, 16'h0, "R5");

        // address mismatch
        frame(32, 2'b10, 5'h1E, 5'd0, 16'h0, "R6");
        frame(32, 2'b01, 5'h00, 5'd0, 16'h0000, "R6");
        frame(32, 2'b10, 5'h1F, 5'd0, 16'h0, "R6");

        // preamble length boundary
        idle(4);
        frame(31, 2'b01, 5'h1F, 5'd0, 16'h0000, "R7");
        idle(4);
        frame(31, 2'b10, 5'h1F, 5'd1, 16'h0, "R7");
        idle(4);
        frame(32, 2'b01, 5'h1F, 5'd0, 16'h0008, "R7");
        frame(32, 2'b10, 5'h1F, 5'd0, 16'h0, "R7");

        // illegal opcodes
        frame(32, 2'b00, 5'h1F, 5'd0, 16'h0, "R10");
        frame(32, 2'b11, 5'h1F, 5'd0, 16'h0, "R10");
        frame(32, 2'b10, 5'h1F, 5'd0, 16'h0, "R10");

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule